// File: doc/BRIEF.md
# Transmit Partial Checksum Inserter

This block sits in a streaming transmit path between a DMA read channel and an Ethernet MAC. Before each frame, software supplies a short set of control words on a separate stream. These words carry an offload switch, a 16-bit seed (normally the pseudo-header sum), the byte index where summing begins, and the byte index where the 16-bit result goes.

The frame is taken whole into an internal store-and-forward buffer. While it arrives, the block accumulates a ones' complement sum of every byte from the start index to the end of the frame. When the frame's last beat is in, the carries are folded and the sum is inverted. The result is then written into the buffered frame at the insertion index, and the frame is released on the output stream. With offload off, the frame is released exactly as received.

Only one frame is resident at a time. The next control set is accepted once the previous frame has fully left.

Top module: `cso_tx_inserter`

## Requirements
- R1: While and right after the synchronous active-low reset, `ctl_ready` is 1, `s_tready` is 0 and `m_tvalid` is 0.
- R2: Control arrives as three 32-bit words, in this order:
  - Word one: the 2-bit switch in bits [11:10]. Only the value 2'b01 turns offload on. All other bits are ignored.
  - Word two: the seed in bits [15:0].
  - Word three: the start index in bits [15:0] and the insertion index in bits [31:16].
  
  After the third word, `ctl_ready` stays 0 until the last output beat of the frame has been taken.
- R3: No frame beat is accepted (`s_tready` is 0) until all three control words of the set are in. Beat lane i (`tdata[8i+7:8i]`) carries frame byte 8*beat+i. `tkeep` is contiguous from lane 0, and only the last beat may be partial.
- R4: When the switch is not 2'b01, the output frame is byte-for-byte, `tkeep` and `tlast` identical to the input.
- R5: With offload on, the sum is seeded with the seed. The bytes are then added as big-endian 16-bit words paired from the start index: byte start+2k is the high half and byte start+2k+1 is the low half. An odd final byte is paired with a zero low half. Bytes before the start index are not summed.
- R6: The sum's end-around carries are folded into 16 bits and the result is inverted. Its high byte replaces frame byte `insert` and its low byte replaces byte `insert+1`, even when the two bytes fall in different beats. Every other byte leaves unchanged.
- R7: An inverted result of 0x0000 is sent as 0x0000, with no substitution.
- R8: No output beat is offered before the input `tlast` has been accepted, and `s_tready` and `m_tvalid` are never high together.
- R9: While `m_tvalid` is high and `m_tready` is low, the output beat stays valid and unchanged.
- R10: Frames up to the buffer size (DEPTH*LANES bytes, 2048 by default) pass intact. `s_tready` is 0 while the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted when high with valid |
| ctl_data | input | 32 | Control word |
| s_tvalid | input | 1 | Input frame beat valid |
| s_tready | output | 1 | Input frame beat accepted |
| s_tdata | input | 8*LANES | Input frame bytes, lane 0 first |
| s_tkeep | input | LANES | Input byte-valid per lane |
| s_tlast | input | 1 | Last beat of input frame |
| m_tvalid | output | 1 | Output frame beat valid |
| m_tready | input | 1 | Output beat taken by the MAC |
| m_tdata | output | 8*LANES | Output frame bytes |
| m_tkeep | output | LANES | Output byte-valid per lane |
| m_tlast | output | 1 | Last beat of output frame |

## Verification
A corrupted accumulator or a wrong pairing parity shows only in the two bytes at the insertion index. It becomes visible once draining starts, which is one full frame plus two patch cycles after the first input beat. The rest of the frame stays correct, so every frame is compared byte by byte.

A bad write or read pointer shows up in the frame length, the `tkeep` pattern or the position of `tlast`. A stuck control-hold flag shows as `ctl_ready` never returning, which hangs the next frame.

The scenarios therefore include:
- odd start indices;
- an insertion that straddles a beat boundary;
- an all-ones carry-heavy frame;
- a zero result;
- a buffer-sized frame;
- an irregular output `m_tready` pattern.

// File: rtl/cso_pkg.sv
// Shared types, constants and the carry-folding helper for the transmit
// checksum inserter. Assumes 16-bit byte indices from the control words.
package cso_pkg;
    localparam int CTL_W   = 32;
    localparam int IDX_W   = 16;
    localparam int ACC_W   = 32;
    localparam int SW_LSB  = 10;
    localparam logic [1:0] OFFLOAD_ON = 2'b01;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_FILL,
        ST_PATCH_HI,
        ST_PATCH_LO,
        ST_DRAIN
    } cso_state_e;

    typedef struct packed {
        logic             enable;
        logic [15:0]      seed;
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] insert;
    } cso_ctl_t;

    // Fold a wide sum into 16 bits with end-around carry (two passes suffice).
    function automatic logic [15:0] fold_ones(input logic [ACC_W-1:0] a);
        logic [16:0] s1;
        logic [16:0] s2;
        s1 = {1'b0, a[15:0]} + {1'b0, a[31:16]};
        s2 = {1'b0, s1[15:0]} + {16'h0, s1[16]};
        return s2[15:0];
    endfunction
endpackage

// File: rtl/cso_ctl_capture.sv
// Collects the three control words of one frame and holds them until the
// top asserts release_i. Assumes words arrive in order: switch, seed, indices.
module cso_ctl_capture
    import cso_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [CTL_W-1:0] ctl_data,
    input  logic             release_i,
    output logic             held_o,
    output cso_ctl_t         fields_o
);
    localparam int NUM_WORDS = 3;
    localparam int WC_W      = $clog2(NUM_WORDS);

    logic [WC_W-1:0] word_q;
    logic            held_q;
    cso_ctl_t        fields_q;

    assign ctl_ready = !held_q;
    assign held_o    = held_q;
    assign fields_o  = fields_q;

    // Capture words by position; hold the full set until released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            held_q   <= 1'b0;
            fields_q <= '0;
        end else if (release_i) begin
            held_q <= 1'b0;
            word_q <= '0;
        end else if (ctl_valid && !held_q) begin
            case (word_q)
                WC_W'(0): fields_q.enable <= (ctl_data[SW_LSB +: 2] == OFFLOAD_ON);
                WC_W'(1): fields_q.seed   <= ctl_data[15:0];
                default: begin
                    fields_q.start  <= ctl_data[IDX_W-1:0];
                    fields_q.insert <= ctl_data[CTL_W-1 -: IDX_W];
                    held_q          <= 1'b1;
                end
            endcase
            word_q <= (word_q == WC_W'(NUM_WORDS - 1)) ? '0 : word_q + 1'b1;
        end
    end
endmodule

// File: rtl/cso_sum_acc.sv
// Ones' complement accumulator over frame beats. Each accepted byte at or
// past the start index adds as a high or low half depending on its distance
// from the start. Assumes keep is contiguous from lane 0.
module cso_sum_acc
    import cso_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PTR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [15:0]        seed_i,
    input  logic               add_i,
    input  logic [PTR_W-1:0]   beat_i,
    input  logic [8*LANES-1:0] data_i,
    input  logic [LANES-1:0]   keep_i,
    input  logic [IDX_W-1:0]   start_i,
    output logic [15:0]        csum_o
);
    localparam int LANE_W = $clog2(LANES);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] beat_sum;
    logic [ACC_W-1:0] base;

    assign base = ACC_W'(beat_i) << LANE_W;

    // Sum this beat's qualifying bytes, each placed in its word half.
    always_comb begin
        beat_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            if (keep_i[i] && ((base + ACC_W'(i)) >= ACC_W'(start_i))) begin
                if ((base[0] ^ 1'(i)) ^ start_i[0])
                    beat_sum = beat_sum + ACC_W'(data_i[8*i +: 8]);
                else
                    beat_sum = beat_sum + (ACC_W'(data_i[8*i +: 8]) << 8);
            end
        end
    end

    // Seed at frame start, then add every accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (load_i)
            acc_q <= ACC_W'(seed_i);
        else if (add_i)
            acc_q <= acc_q + beat_sum;
    end

    assign csum_o = ~fold_ones(acc_q);
endmodule

// File: rtl/cso_frame_buf.sv
// Beat-wide frame store with a byte-wide patch port and asynchronous read.
// Contents are not reset; a location is read only after it was written.
module cso_frame_buf
    import cso_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr_i,
    input  logic [8*LANES-1:0]       wr_data_i,
    input  logic [LANES-1:0]         wr_keep_i,
    input  logic                     patch_en_i,
    input  logic [IDX_W-1:0]         patch_idx_i,
    input  logic [7:0]               patch_byte_i,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr_i,
    output logic [8*LANES-1:0]       rd_data_o,
    output logic [LANES-1:0]         rd_keep_o
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int LANE_W = $clog2(LANES);

    logic [7:0]       mem_q  [DEPTH][LANES];
    logic [LANES-1:0] keep_q [DEPTH];

    logic [PTR_W-1:0]  p_beat;
    logic [LANE_W-1:0] p_lane;
    logic              p_inside;

    assign p_beat   = patch_idx_i[LANE_W +: PTR_W];
    assign p_lane   = patch_idx_i[LANE_W-1:0];
    assign p_inside = (patch_idx_i >> (LANE_W + PTR_W)) == '0;

    // Store incoming beats and apply single-byte patches.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            for (int i = 0; i < LANES; i++)
                mem_q[wr_ptr_i][i] <= wr_data_i[8*i +: 8];
            keep_q[wr_ptr_i] <= wr_keep_i;
        end
        if (patch_en_i && p_inside)
            mem_q[p_beat][p_lane] <= patch_byte_i;
    end

    // Present the beat at the read pointer.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            rd_data_o[8*i +: 8] = mem_q[rd_ptr_i][i];
    end
    assign rd_keep_o = keep_q[rd_ptr_i];
endmodule

// File: rtl/cso_tx_inserter.sv
// Store-and-forward transmit checksum inserter. Waits for a control set,
// buffers one frame while summing it, patches the inverted sum at the
// insertion index, then drains the frame. Assumes frames fit the buffer.
module cso_tx_inserter
    import cso_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_valid,
    output logic               ctl_ready,
    input  logic [CTL_W-1:0]   ctl_data,
    input  logic               s_tvalid,
    output logic               s_tready,
    input  logic [8*LANES-1:0] s_tdata,
    input  logic [LANES-1:0]   s_tkeep,
    input  logic               s_tlast,
    output logic               m_tvalid,
    input  logic               m_tready,
    output logic [8*LANES-1:0] m_tdata,
    output logic [LANES-1:0]   m_tkeep,
    output logic               m_tlast
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    cso_state_e       state_q;
    logic [CNT_W-1:0] wr_cnt_q;
    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] rd_q;

    logic             held;
    cso_ctl_t         fields;
    logic [15:0]      csum;
    logic             buf_full;
    logic             in_fire;
    logic             out_fire;
    logic             release_set;
    logic             patch_en;
    logic [IDX_W-1:0] patch_idx;
    logic [7:0]       patch_byte;

    assign buf_full    = (wr_cnt_q == CNT_W'(DEPTH));
    assign s_tready    = (state_q == ST_FILL) && !buf_full;
    assign in_fire     = s_tvalid && s_tready;
    assign m_tvalid    = (state_q == ST_DRAIN);
    assign m_tlast     = m_tvalid && (rd_q == last_q);
    assign out_fire    = m_tvalid && m_tready;
    assign release_set = out_fire && m_tlast;

    assign patch_en   = (state_q == ST_PATCH_HI) || (state_q == ST_PATCH_LO);
    assign patch_idx  = (state_q == ST_PATCH_HI) ? fields.insert : fields.insert + 1'b1;
    assign patch_byte = (state_q == ST_PATCH_HI) ? csum[15:8] : csum[7:0];

    cso_ctl_capture ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_valid (ctl_valid),
        .ctl_ready (ctl_ready),
        .ctl_data  (ctl_data),
        .release_i (release_set),
        .held_o    (held),
        .fields_o  (fields)
    );

    cso_sum_acc #(.LANES(LANES), .PTR_W(PTR_W)) sum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  ((state_q == ST_WAIT) && held),
        .seed_i  (fields.seed),
        .add_i   (in_fire),
        .beat_i  (wr_cnt_q[PTR_W-1:0]),
        .data_i  (s_tdata),
        .keep_i  (s_tkeep),
        .start_i (fields.start),
        .csum_o  (csum)
    );

    cso_frame_buf #(.LANES(LANES), .DEPTH(DEPTH)) buf_i (
        .clk          (clk),
        .wr_en_i      (in_fire),
        .wr_ptr_i     (wr_cnt_q[PTR_W-1:0]),
        .wr_data_i    (s_tdata),
        .wr_keep_i    (s_tkeep),
        .patch_en_i   (patch_en),
        .patch_idx_i  (patch_idx),
        .patch_byte_i (patch_byte),
        .rd_ptr_i     (rd_q),
        .rd_data_o    (m_tdata),
        .rd_keep_o    (m_tkeep)
    );

    // Sequence one frame: wait for control, fill, optional patch, drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_WAIT;
            wr_cnt_q <= '0;
            last_q   <= '0;
            rd_q     <= '0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (held) begin
                        state_q  <= ST_FILL;
                        wr_cnt_q <= '0;
                    end
                end
                ST_FILL: begin
                    if (in_fire) begin
                        wr_cnt_q <= wr_cnt_q + 1'b1;
                        if (s_tlast) begin
                            last_q  <= wr_cnt_q[PTR_W-1:0];
                            rd_q    <= '0;
                            state_q <= fields.enable ? ST_PATCH_HI : ST_DRAIN;
                        end
                    end
                end
                ST_PATCH_HI: state_q <= ST_PATCH_LO;
                ST_PATCH_LO: state_q <= ST_DRAIN;
                ST_DRAIN: begin
                    if (out_fire) begin
                        if (m_tlast) state_q <= ST_WAIT;
                        else         rd_q    <= rd_q + 1'b1;
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/cso_tx_inserter_chk.sv
// Port-level protocol checks for the transmit checksum inserter, bound to
// every instance of the top module.
module cso_tx_inserter_chk #(
    parameter int LANES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_ready,
    input logic               s_tready,
    input logic               m_tvalid,
    input logic               m_tready,
    input logic [8*LANES-1:0] m_tdata,
    input logic [LANES-1:0]   m_tkeep,
    input logic               m_tlast
);
    // R8
    fill_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tready && m_tvalid));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tkeep) && $stable(m_tlast)));

    // R2
    ctl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> !ctl_ready);

    // R3
    keep_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> m_tkeep[0]);

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_ready && !(m_tvalid && m_tready && m_tlast)) |=> !ctl_ready);
endmodule

bind cso_tx_inserter cso_tx_inserter_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_ready (ctl_ready),
    .s_tready  (s_tready),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tdata   (m_tdata),
    .m_tkeep   (m_tkeep),
    .m_tlast   (m_tlast)
);

// File: tb/cso_tx_inserter_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module cso_tx_inserter_tb_top;
    localparam int LANES = 8;
    localparam int DEPTH = 256;
    localparam int MAXB  = LANES * DEPTH;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctl_valid = 1'b0;
    logic               ctl_ready;
    logic [31:0]        ctl_data = '0;
    logic               s_tvalid = 1'b0;
    logic               s_tready;
    logic [8*LANES-1:0] s_tdata = '0;
    logic [LANES-1:0]   s_tkeep = '0;
    logic               s_tlast = 1'b0;
    logic               m_tvalid;
    logic               m_tready = 1'b0;
    logic [8*LANES-1:0] m_tdata;
    logic [LANES-1:0]   m_tkeep;
    logic               m_tlast;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] in_b  [MAXB];
    logic [7:0] exp_b [MAXB];
    logic [7:0] got_b [MAXB];
    int  got_len;
    bit  keep_bad;
    bit  early_out;
    bit  ctl_rdy_after;

    always #10 clk = ~clk;

    cso_tx_inserter #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic fill_input(input int len, input int pat, input int salt);
        for (int i = 0; i < len; i++) begin
            case (pat)
                1:       in_b[i] = 8'h00;
                2:       in_b[i] = 8'hFF;
                default: in_b[i] = 8'(i * 37 + salt * 11 + 5) ^ 8'(i >> 3);
            endcase
        end
    endtask

    task automatic build_expect(input logic [1:0] sw, input logic [15:0] seed,
                                input int start, input int ins, input int len);
        logic [31:0] acc;
        logic [15:0] res;
        for (int i = 0; i < len; i++) exp_b[i] = in_b[i];
        if (sw == 2'b01) begin
            acc = 32'(seed);
            for (int p = start; p < len; p++) begin
                if (((p - start) % 2) == 0) acc = acc + {16'h0, in_b[p], 8'h00};
                else                        acc = acc + {24'h0, in_b[p]};
            end
            while ((acc >> 16) != 0) acc = (acc & 32'hFFFF) + (acc >> 16);
            res = ~acc[15:0];
            if (ins < len)     exp_b[ins]     = res[15:8];
            if (ins + 1 < len) exp_b[ins + 1] = res[7:0];
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        ctl_valid = 1'b1;
        ctl_data  = w;
        while (!ctl_ready) @(negedge clk);
    endtask

    task automatic send_frame(input int len);
        int nb;
        nb = (len + LANES - 1) / LANES;
        early_out = 1'b0;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tlast  = (b == nb - 1);
            for (int i = 0; i < LANES; i++) begin
                if (b * LANES + i < len) begin
                    s_tdata[8*i +: 8] = in_b[b * LANES + i];
                    s_tkeep[i] = 1'b1;
                end else begin
                    s_tdata[8*i +: 8] = 8'h00;
                    s_tkeep[i] = 1'b0;
                end
            end
            if (m_tvalid) early_out = 1'b1;
            while (!s_tready) begin
                @(negedge clk);
                if (m_tvalid) early_out = 1'b1;
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic recv_frame(input int mode);
        int  cyc;
        bit  done;
        cyc = 0;
        done = 1'b0;
        got_len = 0;
        keep_bad = 1'b0;
        while (!done) begin
            @(negedge clk);
            m_tready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            cyc++;
            if (m_tvalid && m_tready) begin
                for (int i = 0; i < LANES; i++) begin
                    if (m_tkeep[i]) begin
                        if (i > 0 && !m_tkeep[i-1]) keep_bad = 1'b1;
                        if (got_len < MAXB) got_b[got_len] = m_tdata[8*i +: 8];
                        got_len++;
                    end
                end
                if (!m_tlast && m_tkeep != '1) keep_bad = 1'b1;
                if (m_tlast) done = 1'b1;
            end
        end
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    task automatic run_frame(input string tag, input logic [1:0] sw,
                             input logic [15:0] seed, input int start,
                             input int ins, input int len, input int pat,
                             input int mode, input bit split);
        int bad;
        fill_input(len, pat, start + len);
        build_expect(sw, seed, start, ins, len);
        send_word(32'hA5A5F3FF | {20'h0, sw, 10'h0});
        send_word({16'hBEEF, seed});
        if (split) begin
            @(negedge clk);
            ctl_valid = 1'b0;
            repeat (4) @(negedge clk);
            // R3: no frame beat accepted before the third control word
            check(s_tready == 1'b0, "R3", "s_tready before full control set", s_tready, 0);
        end
        send_word({16'(ins), 16'(start)});
        @(negedge clk);
        ctl_valid = 1'b0;
        ctl_rdy_after = ctl_ready;
        send_frame(len);
        recv_frame(mode);
        check(got_len == len, tag, "frame length", got_len, len);
        check(!keep_bad, tag, "tkeep shape", keep_bad, 0);
        bad = -1;
        for (int p = 0; p < len; p++)
            if (bad < 0 && got_b[p] !== exp_b[p]) bad = p;
        if (bad < 0)
            check(1'b1, tag, "frame bytes", 0, 0);
        else
            check(1'b0, tag, $sformatf("byte %0d", bad), got_b[bad], exp_b[bad]);
    endtask

    task automatic t_reset;
        // R1
        check(ctl_ready == 1'b1, "R1", "ctl_ready after reset", ctl_ready, 1);
        check(s_tready == 1'b0, "R1", "s_tready after reset", s_tready, 0);
        check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", m_tvalid, 0);
    endtask

    task automatic t_passthrough;
        // R4: switch values other than 01 leave the frame untouched
        run_frame("R4", 2'b00, 16'h1234, 2, 6, 21, 0, 0, 1'b0);
        run_frame("R4", 2'b10, 16'h1234, 0, 4, 33, 0, 0, 1'b0);
        run_frame("R4", 2'b11, 16'hFFFF, 1, 2, 8, 0, 0, 1'b0);
    endtask

    task automatic t_basic;
        // R5 / R6: even start, aligned insertion
        run_frame("R5", 2'b01, 16'h5A3C, 14, 24, 60, 0, 0, 1'b0);
    endtask

    task automatic t_odd_straddle;
        // R5: odd start, odd trailing byte; R6: insertion across a beat edge
        run_frame("R6", 2'b01, 16'h0101, 3, 15, 46, 0, 0, 1'b0);
    endtask

    task automatic t_zero_result;
        // R7: seed FFFF over zero bytes gives 0000 on the wire
        run_frame("R7", 2'b01, 16'hFFFF, 0, 4, 10, 1, 0, 1'b0);
    endtask

    task automatic t_carry;
        // R6: all-ones bytes force repeated end-around carries
        run_frame("R6", 2'b01, 16'hFFFE, 0, 62, 64, 2, 0, 1'b0);
    endtask

    task automatic t_backpressure;
        // R9 / R8 / R2: irregular m_tready, no early output, control held
        run_frame("R9", 2'b01, 16'h8001, 5, 20, 37, 0, 1, 1'b0);
        check(!early_out, "R8", "output before input tlast", early_out, 0);
        check(ctl_rdy_after == 1'b0, "R2", "ctl_ready while set held", ctl_rdy_after, 0);
    endtask

    task automatic t_gating;
        // R3: frame waits for the whole control set
        run_frame("R3", 2'b01, 16'h0F0F, 1, 9, 27, 0, 0, 1'b1);
    endtask

    task automatic t_max_frame;
        // R10: a frame exactly the buffer size
        run_frame("R10", 2'b01, 16'h7777, 34, 50, MAXB, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_basic();
        t_odd_straddle();
        t_zero_result();
        t_carry();
        t_backpressure();
        t_gating();
        t_max_frame();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule